// File: doc/BRIEF.md
# Edge-Counting Accumulator Bank with Holding Registers

This block counts signal edges on a set of asynchronous input pins. Each pin has its own counter and its own holding register. Each pin first passes through a synchronizer into the bus clock domain. A per-channel two-bit field then picks which edge advances that channel's counter. Two neighbouring channels can be joined into one double-width counter. In that case the lower channel's pin feeds it under a separate edge field, and the upper byte takes the carry.

Counts move into the holding registers in one of two global modes. In latch mode, any of three strobes snapshots every counter at once and clears it:

- the modulus counter reaching zero,
- a write of zero to that modulus counter,
- a force strobe.

In queue mode, a read strobe for one capture channel moves only that channel's counter (or its whole pair) into holding.

Saturation is optional. When enabled, a counter stops at all-ones. When disabled, it wraps. All interfaces are plain control and status pins: there is no data stream and no back-pressure. Counters and holding registers are always visible on flat output buses.

Top module: `pulse_acc_bank`

## Requirements
- R1: After reset every counter on `acc_o` and every holding register on `hold_o` reads zero.
- R2: A channel's edge field selects what it counts: 00 = nothing, 01 = rising edges, 10 = falling edges, 11 = both edges. An edge applied to the pin shows up on `acc_o` at the third rising clock edge after the change.
- R3: With `sat_en_i` low, an unpaired counter at all-ones wraps to zero on its next counted edge.
- R4: With `sat_en_i` high, an unpaired counter at all-ones stays at all-ones when further edges arrive.
- R5: With `queue_mode_i` low, a one-cycle pulse on `mod_zero_i`, `mod_wr_zero_i` or `force_latch_i` copies every counter into its holding register and clears every counter. In this mode `cap_rd_i` has no effect.
- R6: With `queue_mode_i` high, a pulse on `cap_rd_i[c]` copies counter c into holding register c and clears counter c. Other channels keep their values. In this mode the three latch strobes have no effect.
- R7: When `pair_en_i[p]` is high, channel 2p is the low part and channel 2p+1 the high part of one double-width counter. That counter is fed by pin 2p under field `pair_edge_i[2p+1:2p]` (same encoding as R2). The pin of channel 2p+1 and its own edge field are ignored. A low part at all-ones carries into the high part.
- R8: A paired counter saturates at all-ones across both halves when `sat_en_i` is high, and wraps to zero when it is low.
- R9: In queue mode, a read strobe on either channel of an enabled pair transfers and clears both halves of that pair together.
- R10: When a transfer and a counted edge fall in the same cycle, the holding register receives the count from before that edge, and the counter restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous edge inputs, one per channel |
| edge_sel_i | input | 2*NCH | Per-channel edge field, channel c at bits [2c+1:2c] |
| pair_en_i | input | NCH/2 | Join channels 2p and 2p+1 into one counter |
| pair_edge_i | input | NCH | Edge field of each joined pair, pair p at bits [2p+1:2p] |
| sat_en_i | input | 1 | Stop at all-ones instead of wrapping |
| queue_mode_i | input | 1 | 0 = latch mode, 1 = queue mode |
| mod_zero_i | input | 1 | Strobe: modulus counter reached zero |
| mod_wr_zero_i | input | 1 | Strobe: zero written to modulus counter |
| force_latch_i | input | 1 | Strobe: forced latch |
| cap_rd_i | input | NCH | Per-channel capture-holding read strobes |
| acc_o | output | NCH*CW | Counters, channel c at bits [c*CW +: CW] |
| hold_o | output | NCH*CW | Holding registers, same layout as `acc_o` |

## Verification
A transfer and a counted edge can land in the same cycle, and so can a queue read and the other channels' counting. The bench provokes the first overlap by raising every pin and timing a force strobe so that it is sampled on the very edge at which the synchronized rising edge is counted. It then judges the result at the ports: the holding registers must carry the pre-edge counts and every rising-selected counter must read exactly 1. Queue reads are issued on one channel while the others hold non-zero counts, and those other counters and holding registers must stay untouched.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    logic hit;
    case (edge_sel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  // R2: a detected edge lasts exactly one cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall);
endmodule

// File: rtl/pa_pair_counter.sv
module pa_pair_counter
  import pa_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rise,
  input  logic [1:0]    fall,
  input  logic [1:0]    sel_lo,
  input  logic [1:0]    sel_hi,
  input  logic [1:0]    sel_pair,
  input  logic          paired,
  input  logic          sat_en,
  input  logic          queue_mode,
  input  logic          latch_req,
  input  logic [1:0]    rd,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [CW-1:0] hold_lo,
  output logic [CW-1:0] hold_hi
);
  localparam int PW = 2 * CW;

  logic          hit_lo, hit_hi;
  logic          xfer_lo, xfer_hi;
  logic [PW-1:0] wide, wide_nxt;
  logic [CW-1:0] lo_nxt, hi_nxt;

  assign hit_lo  = edge_hit(paired ? sel_pair : sel_lo, rise[0], fall[0]);
  assign hit_hi  = edge_hit(sel_hi, rise[1], fall[1]);
  assign xfer_lo = queue_mode ? (paired ? |rd : rd[0]) : latch_req;
  assign xfer_hi = queue_mode ? (paired ? |rd : rd[1]) : latch_req;
  assign wide    = {cnt_hi, cnt_lo};

  always_comb begin
    // joined counter: clear wins, the same-cycle edge restarts it at 1
    if (xfer_lo)                        wide_nxt = PW'(hit_lo);
    else if (hit_lo && !(sat_en && &wide)) wide_nxt = wide + PW'(1);
    else                                wide_nxt = wide;
    // separate counters
    if (xfer_lo)                          lo_nxt = CW'(hit_lo);
    else if (hit_lo && !(sat_en && &cnt_lo)) lo_nxt = cnt_lo + CW'(1);
    else                                  lo_nxt = cnt_lo;
    if (xfer_hi)                          hi_nxt = CW'(hit_hi);
    else if (hit_hi && !(sat_en && &cnt_hi)) hi_nxt = cnt_hi + CW'(1);
    else                                  hi_nxt = cnt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      hold_lo <= '0;
      hold_hi <= '0;
    end else begin
      if (paired) {cnt_hi, cnt_lo} <= wide_nxt;
      else begin
        cnt_lo <= lo_nxt;
        cnt_hi <= hi_nxt;
      end
      if (xfer_lo) hold_lo <= cnt_lo;
      if (xfer_hi) hold_hi <= cnt_hi;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !paired && !xfer_lo |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + CW'(1)));
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_en && !paired && !xfer_lo && (&cnt_lo) |=> &cnt_lo);
  p_xfer_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lo |=> hold_lo == $past(cnt_lo));
  p_latch_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_mode && !latch_req |=> $stable(hold_lo) && $stable(hold_hi));
  p_queue_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    queue_mode && (rd == 2'b00) |=> $stable(hold_lo) && $stable(hold_hi));
  p_carry_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    paired && !xfer_lo && !hit_lo |=> $stable(cnt_hi) && $stable(cnt_lo));
  p_sat_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_en && paired && !xfer_lo && (&{cnt_hi, cnt_lo}) |=> &{cnt_hi, cnt_lo});
  p_pair_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paired && queue_mode && (rd != 2'b00) |=> (hold_lo == $past(cnt_lo)) && (hold_hi == $past(cnt_hi)));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lo && !paired |=> cnt_lo <= CW'(1));
endmodule

// File: rtl/pulse_acc_bank.sv
module pulse_acc_bank #(
  parameter int NCH         = 4,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_i,
  input  logic [2*NCH-1:0]  edge_sel_i,
  input  logic [NCH/2-1:0]  pair_en_i,
  input  logic [NCH-1:0]    pair_edge_i,
  input  logic              sat_en_i,
  input  logic              queue_mode_i,
  input  logic              mod_zero_i,
  input  logic              mod_wr_zero_i,
  input  logic              force_latch_i,
  input  logic [NCH-1:0]    cap_rd_i,
  output logic [NCH*CW-1:0] acc_o,
  output logic [NCH*CW-1:0] hold_o
);
  localparam int NPAIR = NCH / 2;

  logic [NCH-1:0] rise, fall;
  logic           latch_req;

  assign latch_req = mod_zero_i | mod_wr_zero_i | force_latch_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_i[c]),
      .rise (rise[c]),
      .fall (fall[c])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pa_pair_counter #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise[2*p +: 2]),
      .fall      (fall[2*p +: 2]),
      .sel_lo    (edge_sel_i[4*p +: 2]),
      .sel_hi    (edge_sel_i[4*p+2 +: 2]),
      .sel_pair  (pair_edge_i[2*p +: 2]),
      .paired    (pair_en_i[p]),
      .sat_en    (sat_en_i),
      .queue_mode(queue_mode_i),
      .latch_req (latch_req),
      .rd        (cap_rd_i[2*p +: 2]),
      .cnt_lo    (acc_o[(2*p)*CW +: CW]),
      .cnt_hi    (acc_o[(2*p+1)*CW +: CW]),
      .hold_lo   (hold_o[(2*p)*CW +: CW]),
      .hold_hi   (hold_o[(2*p+1)*CW +: CW])
    );
  end

  // R1: nothing is counted or held in the first cycle out of reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_o == '0) && (hold_o == '0));
endmodule

// File: tb/pulse_acc_bank_test.sv
module pulse_acc_bank_test;
  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam int MAXV = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    pin_i = '0;
  logic [2*NCH-1:0]  edge_sel_i = '0;
  logic [NCH/2-1:0]  pair_en_i = '0;
  logic [NCH-1:0]    pair_edge_i = '0;
  logic              sat_en_i = 1'b0;
  logic              queue_mode_i = 1'b0;
  logic              mod_zero_i = 1'b0;
  logic              mod_wr_zero_i = 1'b0;
  logic              force_latch_i = 1'b0;
  logic [NCH-1:0]    cap_rd_i = '0;
  logic [NCH*CW-1:0] acc_o, hold_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pulse_acc_bank #(.NCH(NCH), .CW(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .edge_sel_i(edge_sel_i),
    .pair_en_i(pair_en_i), .pair_edge_i(pair_edge_i), .sat_en_i(sat_en_i),
    .queue_mode_i(queue_mode_i), .mod_zero_i(mod_zero_i), .mod_wr_zero_i(mod_wr_zero_i),
    .force_latch_i(force_latch_i), .cap_rd_i(cap_rd_i), .acc_o(acc_o), .hold_o(hold_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int acc(input int c);
    return int'(acc_o[c*CW +: CW]);
  endfunction

  function automatic int hold(input int c);
    return int'(hold_o[c*CW +: CW]);
  endfunction

  task automatic pulses(input logic [NCH-1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      pin_i = m; tick(3);
      pin_i = '0; tick(3);
    end
    tick(4);
  endtask

  task automatic fire(input int which);
    case (which)
      0: force_latch_i = 1'b1;
      1: mod_zero_i = 1'b1;
      default: mod_wr_zero_i = 1'b1;
    endcase
    tick(1);
    force_latch_i = 1'b0; mod_zero_i = 1'b0; mod_wr_zero_i = 1'b0;
    tick(1);
  endtask

  task automatic rd(input logic [NCH-1:0] m);
    cap_rd_i = m; tick(1);
    cap_rd_i = '0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int e[NCH];
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      chk("R1 acc", acc(c), 0);
      chk("R1 hold", hold(c), 0);
    end

    // R2 + R5: every edge code on every channel, every latch source
    for (int rot = 0; rot < 4; rot++) begin
      int n;
      n = 2 + rot;
      for (int c = 0; c < NCH; c++) begin
        int s;
        s = (c + rot) % 4;
        edge_sel_i[2*c +: 2] = 2'(s);
        e[c] = (s == 0) ? 0 : (s == 3) ? 2 * n : n;
      end
      pulses('1, n);
      for (int c = 0; c < NCH; c++) chk("R2 count", acc(c), e[c]);
      fire(rot % 3);
      for (int c = 0; c < NCH; c++) begin
        chk("R5 hold", hold(c), e[c]);
        chk("R5 clear", acc(c), 0);
      end
    end

    // R3 wrap: 9 pulses on both edges = 18 edges
    edge_sel_i = '1;
    pulses('1, 9);
    for (int c = 0; c < NCH; c++) chk("R3 wrap", acc(c), 18 % (MAXV + 1));
    fire(0);
    // R4 saturate
    sat_en_i = 1'b1;
    pulses('1, 9);
    for (int c = 0; c < NCH; c++) chk("R4 sat", acc(c), (18 > MAXV) ? MAXV : 18);
    fire(0);
    sat_en_i = 1'b0;

    // R5 read strobes ignored in latch mode
    pulses('1, 2);
    rd('1);
    for (int c = 0; c < NCH; c++) begin
      chk("R5 rd ignored acc", acc(c), 4);
      chk("R5 rd ignored hold", hold(c), MAXV);
    end

    // R6 queue mode
    queue_mode_i = 1'b1;
    fire(0); fire(1); fire(2);
    for (int c = 0; c < NCH; c++) chk("R6 latch ignored", acc(c), 4);
    rd(4'b0100);
    for (int c = 0; c < NCH; c++) begin
      chk("R6 queue acc", acc(c), (c == 2) ? 0 : 4);
      chk("R6 queue hold", hold(c), (c == 2) ? 4 : MAXV);
    end

    // R10 transfer and counted edge in the same cycle
    queue_mode_i = 1'b0;
    edge_sel_i = {NCH{2'b01}};
    pin_i = '1;
    tick(2);
    force_latch_i = 1'b1;
    tick(1);
    force_latch_i = 1'b0;
    pin_i = '0;
    tick(6);
    for (int c = 0; c < NCH; c++) begin
      chk("R10 hold pre-edge", hold(c), (c == 2) ? 0 : 4);
      chk("R10 restart", acc(c), 1);
    end
    fire(0);

    // R7 pairing with carry; pin 1 toggles but is ignored
    pair_en_i = 2'b01;
    pair_edge_i = 4'b0011;
    edge_sel_i = {NCH{2'b01}};
    pulses('1, 10);
    chk("R7 pair low", acc(0), 20 % (MAXV + 1));
    chk("R7 pair high", acc(1), 20 / (MAXV + 1));
    chk("R7 unpaired ch2", acc(2), 10);
    chk("R7 unpaired ch3", acc(3), 10);
    fire(0);

    // R8 paired saturation and wrap: 130 pulses = 260 edges
    sat_en_i = 1'b1;
    pulses(4'b0001, 130);
    chk("R8 sat low", acc(0), MAXV);
    chk("R8 sat high", acc(1), MAXV);
    fire(0);
    sat_en_i = 1'b0;
    pulses(4'b0001, 130);
    chk("R8 wrap low", acc(0), 260 % 256 % (MAXV + 1));
    chk("R8 wrap high", acc(1), (260 % 256) / (MAXV + 1));
    fire(0);

    // R9 queue read on either half moves the pair
    pair_en_i = 2'b11;
    pair_edge_i = 4'b1111;
    pulses('1, 10);
    queue_mode_i = 1'b1;
    rd(4'b0010);
    chk("R9 hold low", hold(0), 4);
    chk("R9 hold high", hold(1), 1);
    chk("R9 clear low", acc(0), 0);
    chk("R9 clear high", acc(1), 0);
    chk("R9 other low kept", acc(2), 4);
    chk("R9 other high kept", acc(3), 1);
    rd(4'b0100);
    chk("R9 pair1 hold low", hold(2), 4);
    chk("R9 pair1 hold high", hold(3), 1);
    chk("R9 pair1 clear", acc(2) + acc(3), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule